// File: doc/BRIEF.md
# Counter Bit-Transition Event Generator

This block produces periodic events from a free-running 64-bit time base. It watches one low-order bit of a counter, which software selects, and pulses an event whenever that bit flips in the chosen direction. It holds two independent sources. The kernel source follows the virtual counter under its own control word. The hypervisor source follows the physical counter under a second control word. The two events are merged into one interrupt request.

Each control word carries three fields. Bit 2 enables the source. Bit 3 selects the polarity, where 0 means rising and 1 means falling. Bits 7:4 give the index of the watched bit, from 0 to 15. Comparisons are only made on cycles where `tick_i` is high. On such a cycle the counter inputs hold the freshly advanced value. The previous value is taken as that value minus one, so a control change between ticks cannot invent an edge. A global interrupt-mask input silences both sources.

Top module: `evt_stream_gen`

## Requirements
- R1: When bit 2 of a source's control word is 0, that source never produces an event.
- R2: Control bits 7:4 select which counter bit (index 0 to 15) is watched; bits at other indices have no influence on that source.
- R3: With control bit 3 at 0, an event fires when the watched bit is 1 in the current counter value and 0 in (current value - 1).
- R4: With control bit 3 at 1, an event fires when the watched bit is 0 in the current counter value and 1 in (current value - 1).
- R5: While `irq_mask_i` is 1 during a tick, neither source raises an event for that tick.
- R6: `kern_evt_o` is derived from `virt_cnt_i` and `kern_ctl_i` only; `hyp_evt_o` from `phys_cnt_i` and `hyp_ctl_i` only.
- R7: A qualifying tick in cycle N gives a one-cycle high pulse on the source's event output in cycle N+1; a cycle with `tick_i` at 0 gives no event in the next cycle.
- R8: `irq_o` is high exactly when `kern_evt_o` or `hyp_evt_o` is high, in the same cycle.
- R9: Changing a control word while `tick_i` is 0 produces no event; the new setting applies at the next tick.
- R10: During and right after reset, all outputs are 0.
- R11: A counter value of 0 treats the previous value as all ones, so a falling edge fires for any watched index and a rising edge does not.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| tick_i | input | 1 | Counters advanced this cycle; evaluate edges |
| phys_cnt_i | input | CNT_W | Physical counter value |
| virt_cnt_i | input | CNT_W | Virtual counter value |
| kern_ctl_i | input | CTL_W | Kernel source control word |
| hyp_ctl_i | input | CTL_W | Hypervisor source control word |
| irq_mask_i | input | 1 | Interrupt mask; 1 suppresses events |
| kern_evt_o | output | 1 | Kernel source event pulse |
| hyp_evt_o | output | 1 | Hypervisor source event pulse |
| irq_o | output | 1 | Merged interrupt request |

## Verification
The bench uses the default CNT_W of 64 and CTL_W of 32. The full 64-bit width makes the wrap at a counter value of zero reachable, where the borrow ripples through every bit. Loading counters directly, rather than counting up from reset, brings the index-15 edges near 0x8000 within a few cycles. It also lets the two counters differ, which shows each source reads only its own counter.

// File: rtl/evt_pkg.sv
package evt_pkg;
  localparam int unsigned EN_BIT  = 2;
  localparam int unsigned POL_BIT = 3;
  localparam int unsigned IDX_LSB = 4;
  localparam int unsigned IDX_W   = 4;
  localparam int unsigned IDX_MSB = IDX_LSB + IDX_W - 1;
  localparam int unsigned NUM_SRC = 2;

  typedef struct packed {
    logic             en;
    logic             fall;
    logic [IDX_W-1:0] idx;
  } ctl_fields_t;
endpackage

// File: rtl/evt_ctl_decode.sv
module evt_ctl_decode
  import evt_pkg::*;
#(
  parameter int unsigned CTL_W = 32
) (
  input  logic [CTL_W-1:0] ctl_i,
  output ctl_fields_t      fields_o
);
  logic unused_ctl;

  always_comb begin
    fields_o.en   = ctl_i[EN_BIT];
    fields_o.fall = ctl_i[POL_BIT];
    fields_o.idx  = ctl_i[IDX_MSB:IDX_LSB];
  end

  assign unused_ctl = ^{ctl_i[CTL_W-1:IDX_MSB+1], ctl_i[EN_BIT-1:0]};
endmodule

// File: rtl/evt_bit_edge.sv
module evt_bit_edge
  import evt_pkg::*;
#(
  parameter int unsigned CNT_W = 64
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tick_i,
  input  logic             mask_i,
  input  ctl_fields_t      fields_i,
  input  logic [CNT_W-1:0] cnt_i,
  output logic             evt_o
);
  logic [CNT_W-1:0] watch, prev_cnt;
  logic             cur_hi, prv_hi, hit, fire;

  assign watch    = CNT_W'(1) << fields_i.idx;
  assign prev_cnt = cnt_i - CNT_W'(1);
  assign cur_hi   = |(cnt_i & watch);
  assign prv_hi   = |(prev_cnt & watch);
  assign hit      = fields_i.fall ? (prv_hi & ~cur_hi) : (~prv_hi & cur_hi);
  assign fire     = tick_i & fields_i.en & ~mask_i & hit;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) evt_o <= 1'b0;
    else         evt_o <= fire;
  end

  p_disabled_quiet_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !fields_i.en |=> !evt_o);
  p_pulse_after_tick_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !tick_i |=> !evt_o);
  p_masked_quiet_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mask_i |=> !evt_o);
endmodule

// File: rtl/evt_stream_gen.sv
module evt_stream_gen
  import evt_pkg::*;
#(
  parameter int unsigned CNT_W = 64,
  parameter int unsigned CTL_W = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tick_i,
  input  logic [CNT_W-1:0] phys_cnt_i,
  input  logic [CNT_W-1:0] virt_cnt_i,
  input  logic [CTL_W-1:0] kern_ctl_i,
  input  logic [CTL_W-1:0] hyp_ctl_i,
  input  logic             irq_mask_i,
  output logic             kern_evt_o,
  output logic             hyp_evt_o,
  output logic             irq_o
);
  localparam int unsigned KERN = 0;
  localparam int unsigned HYP  = 1;

  logic [CNT_W-1:0] src_cnt [NUM_SRC];
  logic [CTL_W-1:0] src_ctl [NUM_SRC];
  ctl_fields_t      src_fld [NUM_SRC];
  logic [NUM_SRC-1:0] src_evt;

  // kernel source follows the virtual count, hypervisor the physical one
  assign src_cnt[KERN] = virt_cnt_i;
  assign src_ctl[KERN] = kern_ctl_i;
  assign src_cnt[HYP]  = phys_cnt_i;
  assign src_ctl[HYP]  = hyp_ctl_i;

  for (genvar g = 0; g < NUM_SRC; g++) begin : g_src
    evt_ctl_decode #(.CTL_W(CTL_W)) u_dec (
      .ctl_i    (src_ctl[g]),
      .fields_o (src_fld[g])
    );
    evt_bit_edge #(.CNT_W(CNT_W)) u_edge (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .tick_i   (tick_i),
      .mask_i   (irq_mask_i),
      .fields_i (src_fld[g]),
      .cnt_i    (src_cnt[g]),
      .evt_o    (src_evt[g])
    );
  end

  assign kern_evt_o = src_evt[KERN];
  assign hyp_evt_o  = src_evt[HYP];
  assign irq_o      = |src_evt;

  p_irq_covers_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (kern_evt_o || hyp_evt_o) |-> irq_o);
  p_irq_has_src_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> (kern_evt_o || hyp_evt_o));
  p_no_tick_no_irq_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !tick_i |=> !irq_o);
  p_mask_no_irq_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_i && irq_mask_i) |=> !irq_o);
endmodule

// File: tb/tb_evt_stream_gen.sv
module tb_evt_stream_gen;
  localparam int unsigned CNT_W  = 64;
  localparam int unsigned CTL_W  = 32;
  localparam time         CLK_P  = 10ns;
  localparam int unsigned WD_CYC = 20000;

  typedef struct {
    logic  k, h, i;
    string tag;
  } exp_t;

  logic             clk_i = 1'b0, rst_ni = 1'b0, tick_i = 1'b0, irq_mask_i = 1'b0;
  logic [CNT_W-1:0] phys_cnt_i = '0, virt_cnt_i = '0;
  logic [CTL_W-1:0] kern_ctl_i = '0, hyp_ctl_i = '0;
  logic             kern_evt_o, hyp_evt_o, irq_o;

  exp_t exp_q[$];
  int   n_chk = 0, n_fail = 0;
  bit   done  = 1'b0;

  evt_stream_gen #(.CNT_W(CNT_W), .CTL_W(CTL_W)) dut (.*);

  always #(CLK_P/2) clk_i = ~clk_i;

  function automatic logic model(logic [CNT_W-1:0] c, logic [CTL_W-1:0] ctl, logic m, logic t);
    logic [CNT_W-1:0] p;
    logic cb, pb;
    int   ix;
    ix = int'(ctl[7:4]);
    p  = c - 1;
    cb = c[ix];
    pb = p[ix];
    if (!t || m || !ctl[2]) return 1'b0;
    return ctl[3] ? (pb && !cb) : (!pb && cb);
  endfunction

  task automatic step(logic t, logic [CNT_W-1:0] pc, logic [CNT_W-1:0] vc,
                      logic [CTL_W-1:0] kc, logic [CTL_W-1:0] hc, logic m, string tag);
    exp_t e;
    @(negedge clk_i);
    tick_i = t; phys_cnt_i = pc; virt_cnt_i = vc;
    kern_ctl_i = kc; hyp_ctl_i = hc; irq_mask_i = m;
    e.k = model(vc, kc, m, t);
    e.h = model(pc, hc, m, t);
    e.i = e.k | e.h;
    e.tag = tag;
    exp_q.push_back(e);
  endtask

  // monitor: one expected item per cycle, sampled a quarter period after the edge
  always @(posedge clk_i) begin
    #(CLK_P/4);
    if (exp_q.size() > 0) begin
      exp_t e;
      e = exp_q.pop_front();
      n_chk++;
      if ({kern_evt_o, hyp_evt_o, irq_o} !== {e.k, e.h, e.i}) begin
        n_fail++;
        $display("FAIL %s: k/h/irq actual %b%b%b expected %b%b%b", e.tag,
                 kern_evt_o, hyp_evt_o, irq_o, e.k, e.h, e.i);
      end
    end
  end

  initial begin
    repeat (WD_CYC) @(posedge clk_i);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk_i);
    n_chk++; // R10 outputs low in reset
    if ({kern_evt_o, hyp_evt_o, irq_o} !== 3'b000) begin
      n_fail++;
      $display("FAIL R10: actual %b%b%b expected 000", kern_evt_o, hyp_evt_o, irq_o);
    end
    rst_ni = 1'b1;
    @(negedge clk_i);
    n_chk++; // R10 outputs low after release
    if ({kern_evt_o, hyp_evt_o, irq_o} !== 3'b000) begin
      n_fail++;
      $display("FAIL R10: actual %b%b%b expected 000", kern_evt_o, hyp_evt_o, irq_o);
    end

    // R3 rising on bit 0 of virtual count, kernel source
    for (int c = 1; c <= 8; c++) step(1, 64'd500 + 64'(c), 64'(c), 32'h04, 32'h0, 0, "R3");
    // R4 falling on bit 2
    for (int c = 1; c <= 12; c++) step(1, 64'd0, 64'(c), 32'h2C, 32'h0, 0, "R4");
    // R2 index 15 on hypervisor source, stepped across 0x8000 and back to 0x10000
    for (int c = 0; c < 4; c++) step(1, 64'h7FFE + 64'(c), 64'd3, 32'h0, 32'hF4, 0, "R2");
    step(1, 64'h10000, 64'd3, 32'h0, 32'hFC, 0, "R2");
    step(1, 64'h10000, 64'd3, 32'h0, 32'h74, 0, "R2");
    step(1, 64'h0080, 64'd3, 32'h0, 32'h74, 0, "R2");
    // R6 and R8: both sources, different counters
    for (int c = 0; c < 10; c++)
      step(1, 64'h40 + 64'(c), 64'h1000 + 64'(2*c), 32'h14, 32'h1C, 0, "R6_R8");
    step(1, 64'h2, 64'h1, 32'h04, 32'h14, 0, "R8");
    // R5 mask silences both
    step(1, 64'h2, 64'h1, 32'h04, 32'h14, 1, "R5");
    step(1, 64'h8000, 64'h8000, 32'hF4, 32'hF4, 1, "R5");
    // R1 enable clear
    step(1, 64'h2, 64'h1, 32'h00, 32'h10, 0, "R1");
    step(1, 64'h8000, 64'h8000, 32'hF8, 32'hF0, 0, "R1");
    // R7 no tick, values that would hit
    step(0, 64'h2, 64'h1, 32'h04, 32'h14, 0, "R7");
    step(1, 64'h2, 64'h1, 32'h04, 32'h14, 0, "R7");
    step(0, 64'h2, 64'h1, 32'h04, 32'h14, 0, "R7");
    // R9 control changes between ticks
    step(0, 64'h10, 64'h10, 32'h44, 32'h4C, 0, "R9");
    step(0, 64'h10, 64'h10, 32'h04, 32'h0C, 0, "R9");
    step(0, 64'h10, 64'h10, 32'h44, 32'h44, 0, "R9");
    step(1, 64'h10, 64'h10, 32'h44, 32'h44, 0, "R9");
    // R11 wrap at zero
    step(1, 64'h0, 64'h0, 32'h9C, 32'h94, 0, "R11");
    step(1, 64'h0, 64'h0, 32'h0C, 32'hFC, 0, "R11");
    step(0, 64'h0, 64'h0, 32'h0, 32'h0, 0, "R7");

    repeat (3) @(negedge clk_i);
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule